// File: doc/BRIEF.md
# Interrupt latency timestamp unit

This block measures how many system clock cycles a processor takes to react to an interrupt. A free-running counter advances on every clock. The counter value is copied into a first timestamp register when a chosen interrupt line is raised. It is copied into a second register when the processor signals that it has taken that interrupt. Software reads both values and subtracts the first from the second. The result is the number of cycles between the request and the moment execution reached the trap handler.

The monitored interrupt number is held in a control register. Writing that register also re-arms the unit for a new measurement. Once a request has been stamped, the unit waits for the matching acknowledge. After that, both stamps are frozen until software writes the control register again.

The register port is a plain strobe interface with no back-pressure. A read or write is accepted in every cycle in which its strobe is high. Read data comes back exactly one cycle later, marked by a one-cycle valid pulse. The interrupt request and acknowledge inputs are single-cycle event strobes, and they are not stalled either.

Top module: `irq_latency_stamp`

## Requirements
- R1: The counter advances by exactly one on every clock edge after reset. Reading address 4 returns its value at the edge where the read is accepted, zero-extended to 32 bits.
- R2: In the idle state, a cycle with `irq_req` high and `irq_num` equal to the selected number stores the counter value in the assertion stamp (address 2). A later acknowledge of that number stores the counter value in the acknowledge stamp (address 3). The acknowledge stamp minus the assertion stamp equals the number of clock edges between the two events.
- R3: Requests and acknowledges that carry any number other than the selected one change neither the stamps nor the status.
- R4: While a measurement waits for its acknowledge, further requests of the selected number do not overwrite the assertion stamp.
- R5: Status (address 1) bit 0 is set once both stamps are valid, and bit 1 is set while the unit waits for the acknowledge. At most one of the two bits is set at a time. While bit 0 is set, new requests and acknowledges leave both stamps unchanged.
- R6: A write to the control register (address 0) stores the selected number from write data bits [IRQ_W-1:0] and returns the status to 0. Stamp values are kept. If a request arrives in the same cycle as that write, the request is ignored.
- R7: The counter wraps modulo 2^CNT_W. The unsigned difference of the two stamps, taken modulo 2^CNT_W, stays correct across one wrap.
- R8: Reset clears the counter, both stamps, the status and the selected number.
- R9: An acknowledge of the selected number while the unit is idle is ignored.
- R10: `reg_rvalid` is high exactly one cycle after each cycle with `reg_rd` high, and at no other time. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter advances on each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request event strobe |
| irq_num | input | IRQ_W | Number of the interrupt being requested |
| ack_req | input | 1 | Processor acknowledge event strobe |
| ack_num | input | IRQ_W | Number of the interrupt being acknowledged |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 status, 2 assertion stamp, 3 acknowledge stamp, 4 counter |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid together with `reg_rvalid` |
| reg_rvalid | output | 1 | One-cycle pulse marking returned read data |

## Verification
The stamp pair is tried with clean request/acknowledge pairs of several gaps, which shows whether the difference tracks the gap exactly. It is also tried with events carrying foreign numbers, which shows whether the selector filters both inputs. Repeated requests before the acknowledge separate first-event capture from last-event capture. Events arriving after completion show whether the result is frozen. A request issued in the same cycle as a control write shows which of the two wins. A second instance with an 8-bit counter is driven so that the request lands just before the wrap, showing that modular subtraction gives the true latency. Counter reads taken at known edges pin down the absolute stamp values against the reset point.

// File: rtl/ils_pkg.sv
package ils_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_ASRT   = 3'd2;
  localparam logic [ADDR_W-1:0] A_ACK    = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;

  localparam int ST_DONE_BIT = 0;
  localparam int ST_WAIT_BIT = 1;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_WAIT = 2'd1,
    CAP_DONE = 2'd2
  } cap_state_e;
endpackage

// File: rtl/ils_freerun.sv
module ils_freerun #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  // R1, R7: one step per edge, wrapping modulo 2^CNT_W
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/ils_capture.sv
module ils_capture
  import ils_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int IRQ_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [IRQ_W-1:0] sel_i,
  input  logic             clr_i,
  input  logic             irq_req,
  input  logic [IRQ_W-1:0] irq_num,
  input  logic             ack_req,
  input  logic [IRQ_W-1:0] ack_num,
  output logic [CNT_W-1:0] asrt_stamp_o,
  output logic [CNT_W-1:0] ack_stamp_o,
  output logic             waiting_o,
  output logic             done_o
);
  cap_state_e       state_q, state_d;
  logic [CNT_W-1:0] asrt_q, ack_q;
  logic             irq_hit, ack_hit;
  logic             take_asrt, take_ack;

  assign irq_hit = irq_req && (irq_num == sel_i);
  assign ack_hit = ack_req && (ack_num == sel_i);

  always_comb begin
    state_d   = state_q;
    take_asrt = 1'b0;
    take_ack  = 1'b0;
    if (clr_i) begin
      state_d = CAP_IDLE;
    end else begin
      case (state_q)
        CAP_IDLE: if (irq_hit) begin
          state_d   = CAP_WAIT;
          take_asrt = 1'b1;
        end
        CAP_WAIT: if (ack_hit) begin
          state_d  = CAP_DONE;
          take_ack = 1'b1;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      asrt_q  <= '0;
      ack_q   <= '0;
    end else begin
      state_q <= state_d;
      if (take_asrt) asrt_q <= cnt_i;
      if (take_ack)  ack_q  <= cnt_i;
    end
  end

  assign asrt_stamp_o = asrt_q;
  assign ack_stamp_o  = ack_q;
  assign waiting_o    = (state_q == CAP_WAIT);
  assign done_o       = (state_q == CAP_DONE);

  // R2, R3, R9: leaving idle needs a matching request
  p_idle_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAP_IDLE && !irq_hit) |=> state_q == CAP_IDLE);

  // R4: the assertion stamp is held once a measurement is running
  p_asrt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != CAP_IDLE) |=> $stable(asrt_q));

  // R5: completion only follows a matching acknowledge
  p_done_from_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAP_WAIT && !ack_hit) |=> state_q != CAP_DONE);

  // R5: a completed result stays frozen until a control write
  p_done_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAP_DONE && !clr_i) |=> (state_q == CAP_DONE && $stable(ack_q)));

  // R5: status bits are mutually exclusive
  p_status_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({waiting_o, done_o}));

  // R6: a control write returns the unit to idle
  p_clr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> state_q == CAP_IDLE);
endmodule

// File: rtl/ils_regbus.sv
module ils_regbus
  import ils_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int IRQ_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  asrt_stamp_i,
  input  logic [CNT_W-1:0]  ack_stamp_i,
  input  logic              waiting_i,
  input  logic              done_i,
  output logic [IRQ_W-1:0]  sel_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid
);
  logic [IRQ_W-1:0]  sel_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rvalid_q;
  logic              ctrl_wr;
  logic              unused_wdata_hi;

  assign ctrl_wr         = reg_wr && (reg_addr == A_CTRL);
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:IRQ_W];

  always_comb begin
    rdata_d = '0;
    case (reg_addr)
      A_CTRL:   rdata_d = DATA_W'(sel_q);
      A_STATUS: begin
        rdata_d[ST_DONE_BIT] = done_i;
        rdata_d[ST_WAIT_BIT] = waiting_i;
      end
      A_ASRT:   rdata_d = DATA_W'(asrt_stamp_i);
      A_ACK:    rdata_d = DATA_W'(ack_stamp_i);
      A_COUNT:  rdata_d = DATA_W'(cnt_i);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (ctrl_wr) sel_q <= reg_wdata[IRQ_W-1:0];
      rvalid_q <= reg_rd;
      if (reg_rd) rdata_q <= rdata_d;
    end
  end

  assign sel_o      = sel_q;
  assign clr_o      = ctrl_wr;
  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;

  // R10: read data returns exactly one cycle after the strobe
  p_rvalid_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
  p_no_rvalid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  // R6: the selector only moves on a control write
  p_sel_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(sel_q));
endmodule

// File: rtl/irq_latency_stamp.sv
module irq_latency_stamp
  import ils_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int IRQ_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [IRQ_W-1:0]  irq_num,
  input  logic              ack_req,
  input  logic [IRQ_W-1:0]  ack_num,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] asrt_stamp, ack_stamp;
  logic [IRQ_W-1:0] sel;
  logic             clr, waiting, done;

  ils_freerun #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_o (cnt)
  );

  ils_capture #(.CNT_W(CNT_W), .IRQ_W(IRQ_W)) u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_i        (cnt),
    .sel_i        (sel),
    .clr_i        (clr),
    .irq_req      (irq_req),
    .irq_num      (irq_num),
    .ack_req      (ack_req),
    .ack_num      (ack_num),
    .asrt_stamp_o (asrt_stamp),
    .ack_stamp_o  (ack_stamp),
    .waiting_o    (waiting),
    .done_o       (done)
  );

  ils_regbus #(.CNT_W(CNT_W), .IRQ_W(IRQ_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .cnt_i        (cnt),
    .asrt_stamp_i (asrt_stamp),
    .ack_stamp_i  (ack_stamp),
    .waiting_i    (waiting),
    .done_i       (done),
    .sel_o        (sel),
    .clr_o        (clr),
    .reg_rdata    (reg_rdata),
    .reg_rvalid   (reg_rvalid)
  );

  // R8: right after reset the unit is idle and stamps are zero
  p_reset_clean_r8: assert property (@(posedge clk)
    !rst_n |=> (!waiting && !done && asrt_stamp == '0 && ack_stamp == '0 && cnt == '0));
endmodule

// File: tb/irq_latency_stamp_tb.sv
module irq_latency_stamp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0, ack_req = 1'b0;
  logic [4:0]  irq_num = '0, ack_num = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata_w;
  logic        rvalid, rvalid_w;

  always #4 clk = ~clk;

  irq_latency_stamp u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_num(irq_num),
    .ack_req(ack_req), .ack_num(ack_num), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata), .reg_rvalid(rvalid));

  irq_latency_stamp #(.CNT_W(8)) u_wrap (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_num(irq_num),
    .ack_req(ack_req), .ack_num(ack_num), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_w), .reg_rvalid(rvalid_w));

  int pc = 0;
  always @(posedge clk) pc <= pc + 1;

  typedef struct {
    bit          wrap;
    bit          cmp;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t q[$];

  int          errors = 0, checks = 0;
  int          p0 = 0;
  logic [31:0] last_rdata = '0;
  bit          finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as read data returns
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      exp_t        it;
      logic [31:0] got;
      if (q.size() == 0) begin
        chk(1'b0, "R10 read data without request", rdata, 32'h0);
      end else begin
        it  = q.pop_front();
        got = it.wrap ? rdata_w : rdata;
        last_rdata = got;
        if (it.cmp) chk(got == it.exp, it.tag, got, it.exp);
      end
    end
  end

  // driver: read with expected value; rel makes it the counter at the read edge
  task automatic rd(input logic [2:0] a, input bit wrap, input bit cmp, input logic [31:0] exp,
                    input string tag, input bit rel = 1'b0);
    logic [31:0] e;
    @(negedge clk);
    e = exp;
    if (rel) e = 32'(pc - p0);
    if (wrap) e = e & 32'hFF;
    reg_rd = 1'b1; reg_addr = a;
    q.push_back('{wrap, cmp, e, tag});
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_get(input logic [2:0] a, input bit wrap, output logic [31:0] v);
    rd(a, wrap, 1'b0, 32'h0, "");
    #1 v = last_rdata;
  endtask

  task automatic wr_ctrl(input logic [4:0] sel, input bit with_irq = 1'b0, input logic [4:0] num = '0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'(sel);
    irq_req = with_irq; irq_num = num;
    @(negedge clk);
    reg_wr = 1'b0; irq_req = 1'b0;
  endtask

  task automatic pulse_irq(input logic [4:0] num, output int idx);
    @(negedge clk);
    irq_req = 1'b1; irq_num = num; idx = pc;
    @(negedge clk);
    irq_req = 1'b0;
  endtask

  task automatic pulse_ack(input logic [4:0] num, output int idx);
    @(negedge clk);
    ack_req = 1'b1; ack_num = num; idx = pc;
    @(negedge clk);
    ack_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int          i0, i1, j0, j1, j2, k0, k1, w0, w1, dummy;
    logic [31:0] a, a2, aw, ackw;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    p0 = pc;

    // R8: reset state
    rd(3'd0, 0, 1, 32'h0, "R8 selector after reset");
    rd(3'd1, 0, 1, 32'h0, "R8 status after reset");
    rd(3'd2, 0, 1, 32'h0, "R8 assertion stamp after reset");
    rd(3'd3, 0, 1, 32'h0, "R8 acknowledge stamp after reset");
    rd(3'd4, 0, 1, 32'h0, "R8 counter from reset", 1'b1);
    // R1: counter advances one per edge
    idle(7);
    rd(3'd4, 0, 1, 32'h0, "R1 counter step", 1'b1);
    rd(3'd4, 1, 1, 32'h0, "R1 narrow counter step", 1'b1);
    // R10: unmapped address
    rd(3'd6, 0, 1, 32'h0, "R10 unmapped address reads zero");

    // R6: selector write
    wr_ctrl(5'd5);
    rd(3'd0, 0, 1, 32'd5, "R6 selector readback");

    // R3: foreign request
    pulse_irq(5'd4, dummy);
    idle(2);
    rd(3'd1, 0, 1, 32'h0, "R3 foreign request ignored");
    // R9: acknowledge while idle
    pulse_ack(5'd5, dummy);
    rd(3'd1, 0, 1, 32'h0, "R9 idle acknowledge ignored");
    rd(3'd3, 0, 1, 32'h0, "R9 acknowledge stamp untouched");

    // R2: measurement
    pulse_irq(5'd5, i0);
    rd(3'd1, 0, 1, 32'h2, "R5 waiting bit");
    pulse_ack(5'd6, dummy);
    rd(3'd1, 0, 1, 32'h2, "R3 foreign acknowledge ignored");
    idle(5);
    pulse_ack(5'd5, i1);
    rd(3'd1, 0, 1, 32'h1, "R5 done bit");
    rd_get(3'd2, 0, a);
    chk(a == 32'(i0 - p0), "R2 assertion stamp value", a, 32'(i0 - p0));
    rd(3'd3, 0, 1, a + 32'(i1 - i0), "R2 latency difference");

    // R5: frozen after completion
    pulse_irq(5'd5, dummy);
    idle(3);
    pulse_ack(5'd5, dummy);
    rd(3'd2, 0, 1, a, "R5 assertion stamp frozen");
    rd(3'd3, 0, 1, a + 32'(i1 - i0), "R5 acknowledge stamp frozen");
    rd(3'd1, 0, 1, 32'h1, "R5 done held");

    // R6: control write clears status, keeps stamps
    wr_ctrl(5'd5);
    rd(3'd1, 0, 1, 32'h0, "R6 status cleared");
    rd(3'd2, 0, 1, a, "R6 stamps kept");

    // R4: repeated request does not overwrite
    pulse_irq(5'd5, j0);
    idle(2);
    pulse_irq(5'd5, j1);
    idle(4);
    pulse_ack(5'd5, j2);
    rd(3'd2, 0, 1, 32'(j0 - p0), "R4 first request kept");
    rd(3'd3, 0, 1, 32'(j2 - p0), "R2 acknowledge stamp value");

    // R6: write wins over a request in the same cycle
    wr_ctrl(5'd5, 1'b1, 5'd5);
    idle(1);
    rd(3'd1, 0, 1, 32'h0, "R6 write beats simultaneous request");
    pulse_ack(5'd5, dummy);
    rd(3'd1, 0, 1, 32'h0, "R6 no measurement armed");

    // R6: new selector
    wr_ctrl(5'd9);
    pulse_irq(5'd5, dummy);
    rd(3'd1, 0, 1, 32'h0, "R6 old number no longer watched");
    pulse_irq(5'd9, k0);
    idle(3);
    pulse_ack(5'd9, k1);
    rd(3'd1, 0, 1, 32'h1, "R6 new number measured");
    rd_get(3'd2, 0, a2);
    chk(a2 == 32'(k0 - p0), "R6 new assertion stamp", a2, 32'(k0 - p0));
    rd(3'd3, 0, 1, 32'(k1 - p0), "R6 new acknowledge stamp");

    // R7: wrap of the narrow counter between request and acknowledge
    wr_ctrl(5'd3);
    while (((pc - p0) & 255) != 249) @(negedge clk);
    pulse_irq(5'd3, w0);
    idle(10);
    pulse_ack(5'd3, w1);
    rd_get(3'd2, 1, aw);
    chk(aw == 32'd250, "R7 narrow stamp before wrap", aw, 32'd250);
    rd_get(3'd3, 1, ackw);
    chk(ackw < aw, "R7 acknowledge stamp wrapped", ackw, aw);
    chk(((ackw - aw) & 32'hFF) == 32'(w1 - w0), "R7 modular latency", (ackw - aw) & 32'hFF, 32'(w1 - w0));
    rd(3'd3, 0, 1, 32'(w1 - p0), "R7 wide counter unaffected");

    idle(3);
    chk(q.size() == 0, "R10 all reads answered", 32'(q.size()), 32'h0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule